// File: doc/BRIEF.md
# Paired-Instruction Fetch Sequencer

This block is the fetch half of a stored-program control unit whose memory words each carry two instructions. A program counter points at instruction pairs. When no instruction is waiting, the sequencer reads one 40-bit word from a synchronous single-port memory into a memory buffer register. It then splits that word: the left instruction is issued now and the right one is parked in an instruction buffer register. The next fetch takes the parked instruction and does not touch memory.

Each issued instruction goes to an execute stage as an 8-bit opcode and a 12-bit address. It is held until the execute stage signals done, which may carry a jump. Fetch and execute strictly alternate and never overlap. A taken jump reloads the program counter and drops any parked instruction. A jump-to-right variant issues only the right instruction of the target word. Fetching from a word index beyond the memory size halts the sequencer with a sticky fault.

Top module: `pairfetch_seq`

## Requirements
- R1: Synchronous active-low reset clears the program counter to 0, empties the instruction buffer, clears the fault and starts in the fetch sub-cycle. The first instruction issued after reset is the left half of word 0. issue_valid and fault are low while reset is held.
- R2: A word splits into a left instruction in bits 39:20 and a right instruction in bits 19:0. In each 20-bit instruction the opcode is bits 19:12 and the address is bits 11:0. The left instruction is issued before the right one.
- R3: A fetch from memory pulses mem_rd_en for one cycle. Read data is expected one clock later. issue_valid rises 3 cycles after the done cycle (read, data capture, split). A fetch served from the buffer makes no memory read, and issue_valid rises 1 cycle after the done cycle.
- R4: Each memory read uses the program counter as its address, and the counter then increments by one. Issuing a parked right instruction leaves the counter unchanged, so uninterrupted execution reads consecutive word addresses.
- R5: An issued instruction keeps issue_valid high and its opcode and address stable until exec_done is sampled high. exec_done, exec_jump and exec_target have no effect while no instruction is issued.
- R6: exec_done together with exec_jump loads exec_target into the program counter and discards a parked instruction. The next issue is the left half of the target word.
- R7: exec_done together with exec_jump_right loads exec_target. It then issues only the right half of the target word, and the following fetch reads word exec_target+1.
- R8: A fetch that needs memory while the program counter is 1000 or more raises fault. fault stays high, and no memory read or issue occurs until reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| mem_rd_en | output | 1 | Memory read strobe, one cycle per word fetch |
| mem_addr | output | 12 | Word address of the read |
| mem_rdata | input | 40 | Read data, valid one clock after the strobe |
| issue_valid | output | 1 | An instruction is presented to the execute stage |
| issue_opcode | output | 8 | Opcode of the issued instruction |
| issue_addr | output | 12 | Address field of the issued instruction |
| exec_done | input | 1 | Execute stage has finished the issued instruction |
| exec_jump | input | 1 | With exec_done: jump to the left half of exec_target |
| exec_jump_right | input | 1 | With exec_done: jump to the right half of exec_target |
| exec_target | input | 12 | Jump word address |
| fault | output | 1 | Sticky out-of-range fetch fault |

## Verification
The bench goes after a jump taken while a right instruction is parked. A design that kept the stale buffer would issue the old right half instead of the target's left half. It checks the one-cycle buffered path against the read count: a design that re-read memory for the right half, or bumped the counter when issuing it, would show an extra read or a skipped address. The last words, 998 and 999, are run into the fault, along with a direct jump to 1000 and a jump-to-right. A late or missing range check would read outside the memory, a non-sticky fault would resume, and a mishandled right-only jump would issue the left half or skip a word. Done pulses are injected between issues; a design that acted on them would jump or issue early.

// File: rtl/pairfetch_pkg.sv
// Shared widths and types for the paired-instruction fetch sequencer.
// Assumes two equal-width instructions per memory word.
package pairfetch_pkg;
    localparam int OP_W    = 8;
    localparam int ADDR_W  = 12;
    localparam int INSTR_W = OP_W + ADDR_W;
    localparam int HALVES  = 2;
    localparam int WORD_W  = HALVES * INSTR_W;

    typedef struct packed {
        logic [OP_W-1:0]   op;
        logic [ADDR_W-1:0] addr;
    } instr_t;

    typedef enum logic [2:0] {
        ST_FETCH,
        ST_WAIT,
        ST_SPLIT,
        ST_EXEC,
        ST_HALT
    } state_t;
endpackage

// File: rtl/pairfetch_split.sv
// Splits a buffered memory word into its left (upper) and right (lower)
// instructions. Purely combinational; assumes HALVES instructions per word.
module pairfetch_split
    import pairfetch_pkg::*;
(
    input  logic [WORD_W-1:0] word_i,
    output instr_t            left_o,
    output instr_t            right_o
);
    instr_t half [HALVES];

    // slice each instruction out of the word, lowest half first
    for (genvar g = 0; g < HALVES; g++) begin : g_half
        assign half[g] = word_i[g*INSTR_W +: INSTR_W];
    end

    assign right_o = half[0];
    assign left_o  = half[HALVES-1];
endmodule

// File: rtl/pairfetch_pc.sv
// Program counter over instruction-pair (word) addresses. Loads on a jump,
// increments on a memory read, and flags values outside the memory.
// Assumes load and increment are never requested together.
module pairfetch_pc
    import pairfetch_pkg::*;
#(
    parameter int MEM_WORDS = 1000
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              inc_i,
    input  logic              load_i,
    input  logic [ADDR_W-1:0] load_val_i,
    output logic [ADDR_W-1:0] pc_o,
    output logic              oob_o
);
    localparam logic [ADDR_W-1:0] LIMIT = ADDR_W'(MEM_WORDS);

    logic [ADDR_W-1:0] pc_q;

    // counter register: jump load has priority over the read increment
    always_ff @(posedge clk) begin
        if (!rst_n)      pc_q <= '0;
        else if (load_i) pc_q <= load_val_i;
        else if (inc_i)  pc_q <= pc_q + 1'b1;
    end

    assign pc_o  = pc_q;
    assign oob_o = (pc_q >= LIMIT);

    // R8
    pc_inc_in_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
        inc_i |-> !oob_o);
endmodule

// File: rtl/pairfetch_ctrl.sv
// Fetch/execute sequencer. Holds the memory buffer, instruction, address
// and instruction buffer registers and the buffer-valid flag. Drives the
// memory read and the handshake to the execute stage.
// Assumes a memory with exactly one clock of read latency.
module pairfetch_ctrl
    import pairfetch_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] pc_i,
    input  logic              pc_oob_i,
    output logic              pc_inc_o,
    output logic              pc_load_o,
    output logic              mem_rd_en_o,
    input  logic [WORD_W-1:0] mem_rdata_i,
    output logic [WORD_W-1:0] mbr_o,
    input  instr_t            left_i,
    input  instr_t            right_i,
    output logic              issue_valid_o,
    output logic [OP_W-1:0]   issue_opcode_o,
    output logic [ADDR_W-1:0] issue_addr_o,
    input  logic              exec_done_i,
    input  logic              exec_jump_i,
    input  logic              exec_jump_right_i,
    output logic              fault_o
);
    state_t            state_q;
    logic [WORD_W-1:0] mbr_q;
    logic [OP_W-1:0]   ir_q;
    logic [ADDR_W-1:0] mar_q;
    instr_t            ibr_q;
    logic              bufv_q;
    logic              ronly_q;
    logic              fault_q;
    logic              jump_taken;

    // memory read when the buffer is empty and the counter is in range
    always_comb begin
        mem_rd_en_o = (state_q == ST_FETCH) && !bufv_q && !pc_oob_i;
        jump_taken  = (state_q == ST_EXEC) && exec_done_i
                      && (exec_jump_i || exec_jump_right_i);
    end

    assign pc_inc_o       = mem_rd_en_o;
    assign pc_load_o      = jump_taken;
    assign mbr_o          = mbr_q;
    assign issue_valid_o  = (state_q == ST_EXEC);
    assign issue_opcode_o = ir_q;
    assign issue_addr_o   = mar_q;
    assign fault_o        = fault_q;

    // sub-cycle sequencing and register transfers
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_FETCH;
            mbr_q   <= '0;
            ir_q    <= '0;
            mar_q   <= '0;
            ibr_q   <= '0;
            bufv_q  <= 1'b0;
            ronly_q <= 1'b0;
            fault_q <= 1'b0;
        end else begin
            case (state_q)
                ST_FETCH: begin
                    if (bufv_q) begin
                        ir_q    <= ibr_q.op;
                        mar_q   <= ibr_q.addr;
                        bufv_q  <= 1'b0;
                        state_q <= ST_EXEC;
                    end else if (pc_oob_i) begin
                        fault_q <= 1'b1;
                        state_q <= ST_HALT;
                    end else begin
                        state_q <= ST_WAIT;
                    end
                end
                ST_WAIT: begin
                    mbr_q   <= mem_rdata_i;
                    state_q <= ST_SPLIT;
                end
                ST_SPLIT: begin
                    if (ronly_q) begin
                        ir_q    <= right_i.op;
                        mar_q   <= right_i.addr;
                        ronly_q <= 1'b0;
                    end else begin
                        ir_q    <= left_i.op;
                        mar_q   <= left_i.addr;
                        ibr_q   <= right_i;
                        bufv_q  <= 1'b1;
                    end
                    state_q <= ST_EXEC;
                end
                ST_EXEC: begin
                    if (exec_done_i) begin
                        state_q <= ST_FETCH;
                        if (jump_taken) begin
                            bufv_q  <= 1'b0;
                            ronly_q <= exec_jump_right_i;
                        end
                    end
                end
                default: state_q <= ST_HALT;
            endcase
        end
    end

    // R8
    fault_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        fault_o |=> fault_o);
    // R8
    no_read_after_fault_chk: assert property (@(posedge clk) disable iff (!rst_n)
        fault_o |-> (!mem_rd_en_o && !issue_valid_o));
    // R5
    issue_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (issue_valid_o && !exec_done_i) |=>
        (issue_valid_o && $stable(issue_opcode_o) && $stable(issue_addr_o)));
    // R3
    single_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
        mem_rd_en_o |=> (!mem_rd_en_o && !issue_valid_o));
    // R3
    buffered_no_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (issue_valid_o && exec_done_i && !exec_jump_i && !exec_jump_right_i && bufv_q)
        |=> !mem_rd_en_o);
endmodule

// File: rtl/pairfetch_seq.sv
// Top of the paired-instruction fetch sequencer: wires the program
// counter, the sequencer and the word splitter. The memory sits outside
// and answers one clock after mem_rd_en.
module pairfetch_seq
    import pairfetch_pkg::*;
#(
    parameter int MEM_WORDS = 1000
) (
    input  logic              clk,
    input  logic              rst_n,
    output logic              mem_rd_en,
    output logic [ADDR_W-1:0] mem_addr,
    input  logic [WORD_W-1:0] mem_rdata,
    output logic              issue_valid,
    output logic [OP_W-1:0]   issue_opcode,
    output logic [ADDR_W-1:0] issue_addr,
    input  logic              exec_done,
    input  logic              exec_jump,
    input  logic              exec_jump_right,
    input  logic [ADDR_W-1:0] exec_target,
    output logic              fault
);
    logic [ADDR_W-1:0] pc;
    logic              pc_oob;
    logic              pc_inc;
    logic              pc_load;
    logic [WORD_W-1:0] mbr;
    instr_t            left_w;
    instr_t            right_w;

    pairfetch_pc #(.MEM_WORDS(MEM_WORDS)) u_pc (
        .clk        (clk),
        .rst_n      (rst_n),
        .inc_i      (pc_inc),
        .load_i     (pc_load),
        .load_val_i (exec_target),
        .pc_o       (pc),
        .oob_o      (pc_oob)
    );

    pairfetch_ctrl u_ctrl (
        .clk               (clk),
        .rst_n             (rst_n),
        .pc_i              (pc),
        .pc_oob_i          (pc_oob),
        .pc_inc_o          (pc_inc),
        .pc_load_o         (pc_load),
        .mem_rd_en_o       (mem_rd_en),
        .mem_rdata_i       (mem_rdata),
        .mbr_o             (mbr),
        .left_i            (left_w),
        .right_i           (right_w),
        .issue_valid_o     (issue_valid),
        .issue_opcode_o    (issue_opcode),
        .issue_addr_o      (issue_addr),
        .exec_done_i       (exec_done),
        .exec_jump_i       (exec_jump),
        .exec_jump_right_i (exec_jump_right),
        .fault_o           (fault)
    );

    pairfetch_split u_split (
        .word_i  (mbr),
        .left_o  (left_w),
        .right_o (right_w)
    );

    assign mem_addr = pc;
endmodule

// File: tb/pairfetch_seq_tb.sv
module pairfetch_seq_tb;
    localparam int CLK_PERIOD = 10;
    localparam int NWORDS     = 1000;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        mem_rd_en;
    logic [11:0] mem_addr;
    logic [39:0] mem_rdata = '0;
    logic        issue_valid;
    logic [7:0]  issue_opcode;
    logic [11:0] issue_addr;
    logic        exec_done = 1'b0;
    logic        exec_jump = 1'b0;
    logic        exec_jump_right = 1'b0;
    logic [11:0] exec_target = '0;
    logic        fault;

    logic [39:0] mem [1024];
    int          rd_count = 0;
    logic [11:0] last_rd = '0;
    int          checks = 0;
    int          errors = 0;
    int          cycles = 0;

    // expected-state model
    int          m_pc;
    bit          m_bufv;
    bit          m_ronly;
    logic [19:0] m_buf;

    pairfetch_seq u_dut (
        .clk(clk), .rst_n(rst_n), .mem_rd_en(mem_rd_en), .mem_addr(mem_addr),
        .mem_rdata(mem_rdata), .issue_valid(issue_valid), .issue_opcode(issue_opcode),
        .issue_addr(issue_addr), .exec_done(exec_done), .exec_jump(exec_jump),
        .exec_jump_right(exec_jump_right), .exec_target(exec_target), .fault(fault)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    // one-clock-latency memory model with read bookkeeping
    always @(posedge clk) begin
        if (mem_rd_en) begin
            mem_rdata <= mem[mem_addr[9:0]];
            last_rd   <= mem_addr;
            rd_count  <= rd_count + 1;
        end
    end

    task automatic report;
        $display("Result: errors=%0d of %0d checks", errors, checks);
    endtask

    always @(posedge clk) begin
        cycles <= cycles + 1;
        if (cycles > 150000) begin
            errors++;
            $display("FAIL watchdog: actual=%0d expected<=150000 cycles", cycles);
            report();
            $finish;
        end
    end

    task automatic chk(input bit ok, input string req, input string what,
                       input longint act, input longint exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    function automatic logic [19:0] left_of(input logic [39:0] w);
        return w[39:20];
    endfunction

    function automatic logic [19:0] right_of(input logic [39:0] w);
        return w[19:0];
    endfunction

    task automatic do_reset;
        @(negedge clk);
        rst_n = 1'b0;
        exec_done = 1'b0; exec_jump = 1'b0; exec_jump_right = 1'b0;
        repeat (3) @(negedge clk);
        chk(!issue_valid && !fault, "R1", "valid/fault in reset",
            {issue_valid, fault}, 0);
        m_pc = 0; m_bufv = 0; m_ronly = 0; m_buf = '0;
        rst_n = 1'b1;
    endtask

    // Waits for the next issue, compares with the model. Returns 1 if a fault was expected.
    task automatic expect_next(input bit spur, input string req, output bit faulted);
        logic [19:0] e;
        int egap, gap, rc0, eread, eaddr;
        logic [7:0]  op0;
        logic [11:0] ad0;
        faulted = 0;
        eaddr = 0;
        if (m_bufv) begin
            e = m_buf; m_bufv = 0; egap = 1; eread = 0;
        end else if (m_pc >= NWORDS) begin
            rc0 = rd_count;
            for (int i = 0; i < 4; i++) begin
                @(negedge clk);
                if (spur) begin exec_done = 1'b1; exec_jump = 1'b1; exec_target = 12'd3; end
            end
            exec_done = 1'b0; exec_jump = 1'b0;
            @(negedge clk);
            chk(fault === 1'b1, "R8", "fault raised", fault, 1);
            chk(!issue_valid, "R8", "no issue after fault", issue_valid, 0);
            chk(rd_count == rc0, "R8", "no read after fault", rd_count - rc0, 0);
            faulted = 1;
            return;
        end else begin
            eaddr = m_pc;
            if (m_ronly) begin
                e = right_of(mem[m_pc]); m_ronly = 0;
            end else begin
                e = left_of(mem[m_pc]); m_buf = right_of(mem[m_pc]); m_bufv = 1;
            end
            m_pc++; egap = 3; eread = 1;
        end
        rc0 = rd_count;
        gap = 0;
        while (!issue_valid && gap < 60) begin
            gap++;
            exec_done   = spur && ($urandom_range(0, 1) == 1);
            exec_jump   = 1'b1;
            exec_target = 12'($urandom_range(0, 999));
            @(negedge clk);
        end
        exec_done = 1'b0; exec_jump = 1'b0;
        chk(issue_valid, req, "issue arrived", issue_valid, 1);
        chk(issue_opcode == e[19:12], req, "opcode", issue_opcode, e[19:12]);
        chk(issue_addr == e[11:0], req, "address", issue_addr, e[11:0]);
        chk(gap == egap, "R3", "issue latency", gap, egap);
        chk(rd_count - rc0 == eread, "R3", "reads per fetch", rd_count - rc0, eread);
        if (eread == 1)
            chk(last_rd == 12'(eaddr), "R4", "read address", last_rd, eaddr);
        op0 = issue_opcode; ad0 = issue_addr;
        repeat ($urandom_range(0, 2)) @(negedge clk);
        chk(issue_valid && issue_opcode == op0 && issue_addr == ad0, "R5", "held until done",
            {issue_valid, issue_opcode, issue_addr}, {1'b1, op0, ad0});
    endtask

    task automatic retire(input bit jmp, input bit jr, input logic [11:0] tgt);
        exec_done = 1'b1; exec_jump = jmp; exec_jump_right = jr; exec_target = tgt;
        @(negedge clk);
        exec_done = 1'b0; exec_jump = 1'b0; exec_jump_right = 1'b0;
        if (jmp || jr) begin
            m_pc = tgt; m_bufv = 0; m_ronly = jr;
        end
    endtask

    initial begin
        bit f;
        int r;
        void'($urandom(32'd20417));
        for (int i = 0; i < 1024; i++) mem[i] = {8'($urandom), 32'($urandom)};

        // R1: reset state and first issue from word 0
        do_reset();
        expect_next(0, "R1", f);

        // R6: jump while the right half of word 0 is parked
        retire(1, 0, 12'd37);
        expect_next(0, "R6", f);
        // R2: right half follows the left half
        retire(0, 0, 12'd0);
        expect_next(0, "R2", f);
        // R4: next read is the following word
        retire(0, 0, 12'd0);
        expect_next(0, "R4", f);

        // R7: jump-to-right issues only the right half, then word+1
        retire(0, 1, 12'd5);
        expect_next(0, "R7", f);
        retire(0, 0, 12'd0);
        expect_next(0, "R7", f);

        // random run with jumps and spurious done pulses between issues (R5)
        for (int n = 0; n < 400; n++) begin
            r = $urandom_range(0, 19);
            if (r == 0)      retire(1, 0, 12'($urandom_range(0, 999)));
            else if (r == 1) retire(0, 1, 12'($urandom_range(0, 999)));
            else             retire(0, 0, 12'd0);
            expect_next(1, "R5", f);
            if (f) begin
                do_reset();
                expect_next(0, "R1", f);
            end
        end

        // R8: run off the end of memory
        retire(1, 0, 12'd998);
        for (int k = 0; k < 4; k++) begin
            expect_next(0, "R2", f);
            retire(0, 0, 12'd0);
        end
        expect_next(1, "R8", f);
        chk(f == 1, "R8", "fault path taken", f, 1);
        repeat (5) @(negedge clk);
        chk(fault && !issue_valid, "R8", "fault stays", {fault, issue_valid}, 2'b10);

        // R1: reset clears the fault; then a direct jump out of range (R8)
        do_reset();
        chk(!fault, "R1", "fault cleared", fault, 0);
        expect_next(0, "R1", f);
        retire(1, 0, 12'd1000);
        expect_next(0, "R8", f);
        chk(f == 1, "R8", "jump out of range faults", f, 1);

        // R7: jump-to-right into the last word, then fault at 1000
        do_reset();
        expect_next(0, "R1", f);
        retire(0, 1, 12'd999);
        expect_next(0, "R7", f);
        retire(0, 0, 12'd0);
        expect_next(0, "R8", f);
        chk(f == 1, "R8", "fault after right-only last word", f, 1);

        report();
        $finish;
    end
endmodule